// File: doc/BRIEF.md
# Three-Channel TMDS Symbol Encoder

This block turns one captured pixel per clock into three 10-bit link symbols, one for each data lane of a digital display link. While the data-enable input is high, each lane codes one 8-bit colour component. A first stage picks XOR or XNOR chaining to reduce transitions. A second stage may invert the byte so that the running ones-versus-zeros balance of the lane stays near zero. While data-enable is low, each lane sends one of four fixed control symbols, picked by two control bits. Lane 0 carries blue with the two sync signals. Lane 1 carries green with one auxiliary bit. Lane 2 carries red with the other two auxiliary bits. Serialisation, the clock lane and line drivers are outside the block.

Each lane holds its balance as a small state machine plus a signed count. The states are `BAL_BLANK` (blanking, count forced to zero), `BAL_ZERO` (video, count zero), `BAL_POS` (video, count positive) and `BAL_NEG` (video, count negative). Any state moves to `BAL_BLANK` whenever data-enable is low. When data-enable is high, any state moves to `BAL_ZERO`, `BAL_POS` or `BAL_NEG` according to the sign of the updated count. Reset puts every lane in `BAL_BLANK`.

Top module: `dvi_tmds_encoder`

## Requirements
- R1: While `rst_n` is low, all three symbol outputs read 1101010100 (bit 9 down to bit 0), and the balance count of every lane is zero.
- R2: A pixel presented before rising edge k appears on all three outputs just after edge k+1, with the three lanes aligned to the same input cycle.
- R3: In blanking, a lane whose control pair (C1,C0) is 00, 01, 10 or 11 emits 1101010100, 0010101011, 0101010100 or 1010101011 respectively (bit 9 first as written).
- R4: In blanking, lane 0 uses `hsync` as C0 and `vsync` as C1.
- R5: In blanking, lane 1 uses `aux[0]` as C0 with C1 held at 0, and lane 2 uses `aux[1]` as C0 and `aux[2]` as C1.
- R6: In video, output bit 8 is 0 when the colour byte has more than four ones, or exactly four ones with bit 0 clear (XNOR chaining). Otherwise bit 8 is 1 (XOR chaining).
- R7: In video, bit 9 flags inversion of bits 7:0. When the count is zero or the chained byte is balanced, bit 9 is the complement of bit 8. Otherwise the byte is inverted exactly when its excess has the same sign as the count.
- R8: Any blanking cycle clears a lane's count, so the first video symbol afterwards is coded as if the count were zero.
- R9: Over the video symbols since the last blanking cycle, the sum of (ones minus zeros) of each lane's outputs stays within -8 to +8.
- R10: Sync and auxiliary inputs have no effect during video, and colour inputs have no effect during blanking.
- R11: A video symbol never equals any of the four control symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| red | input | 8 | Red component, coded on lane 2 |
| green | input | 8 | Green component, coded on lane 1 |
| blue | input | 8 | Blue component, coded on lane 0 |
| de | input | 1 | High for active video, low for blanking |
| hsync | input | 1 | Horizontal sync, lane 0 C0 |
| vsync | input | 1 | Vertical sync, lane 0 C1 |
| aux | input | 3 | Auxiliary control bits for lanes 1 and 2 |
| sym_ch0 | output | 10 | Lane 0 symbol |
| sym_ch1 | output | 10 | Lane 1 symbol |
| sym_ch2 | output | 10 | Lane 2 symbol |

## Verification
The properties assume that every input is a known 0 or 1 at each rising edge once reset is released. They also assume reset is held from time zero until at least one edge has passed, so the checker's own two-stage copy of the inputs starts at zero. The stimulus drives all inputs only on falling edges from fully defined values. It holds reset low over the first edges and releases it on a falling edge. It then walks every control combination, the byte values at the chaining tie, long constant runs that push the balance to its limits, and single-cycle blanking gaps.

// File: rtl/dvi_tmds_pkg.sv
package dvi_tmds_pkg;

    localparam int PIX_W  = 8;
    localparam int SYM_W  = PIX_W + 2;
    localparam int DISP_W = $clog2(PIX_W) + 2;
    localparam int CTL_W  = 2;
    localparam int NUM_CH = 3;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {
        BAL_BLANK,
        BAL_ZERO,
        BAL_POS,
        BAL_NEG
    } bal_state_e;

    typedef struct packed {
        logic             de;
        logic [CTL_W-1:0] ctl;
        logic [PIX_W:0]   qm;
    } stage1_t;

    function automatic sym_t ctrl_token(input logic [CTL_W-1:0] c);
        sym_t t;
        unique case (c)
            2'b00:   t = 10'b1101010100;
            2'b01:   t = 10'b0010101011;
            2'b10:   t = 10'b0101010100;
            default: t = 10'b1010101011;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/dvi_tmds_minimize.sv
module dvi_tmds_minimize
    import dvi_tmds_pkg::*;
(
    input  logic [PIX_W-1:0] pix,
    output logic [PIX_W:0]   qm
);
    int   ones;
    logic use_xnor;
    logic [PIX_W-1:0] chain;

    always_comb begin
        ones     = $countones(pix);
        use_xnor = (ones > PIX_W / 2) || ((ones == PIX_W / 2) && !pix[0]);
        chain    = '0;
        chain[0] = pix[0];
        for (int i = 1; i < PIX_W; i++) begin
            if (use_xnor)
                chain[i] = ~(chain[i-1] ^ pix[i]);
            else
                chain[i] = chain[i-1] ^ pix[i];
        end
        qm = {~use_xnor, chain};
    end

endmodule

// File: rtl/dvi_tmds_balance.sv
module dvi_tmds_balance
    import dvi_tmds_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de,
    input  logic [CTL_W-1:0] ctl,
    input  logic [PIX_W:0]   qm,
    output sym_t             sym
);
    bal_state_e               state_q, state_d;
    logic signed [DISP_W-1:0] disp_q, disp_d;
    sym_t                     sym_q, sym_d;

    int   n_ones;
    int   excess;
    int   sym_bal;
    int   next_cnt;
    logic inv;

    always_comb begin
        n_ones   = $countones(qm[PIX_W-1:0]);
        excess   = 2 * n_ones - PIX_W;
        inv      = 1'b0;
        sym_bal  = 0;
        next_cnt = 0;
        sym_d    = ctrl_token(ctl);
        disp_d   = '0;
        state_d  = BAL_BLANK;
        if (de) begin
            unique case (state_q)
                BAL_BLANK, BAL_ZERO: inv = ~qm[PIX_W];
                BAL_POS:  inv = (excess == 0) ? ~qm[PIX_W] : (excess > 0);
                BAL_NEG:  inv = (excess == 0) ? ~qm[PIX_W] : (excess < 0);
            endcase
            sym_d    = {inv, qm[PIX_W], inv ? ~qm[PIX_W-1:0] : qm[PIX_W-1:0]};
            sym_bal  = (inv ? 1 : -1) + (qm[PIX_W] ? 1 : -1) + (inv ? -excess : excess);
            next_cnt = int'(disp_q) + sym_bal;
            disp_d   = DISP_W'(next_cnt);
            if (next_cnt == 0)
                state_d = BAL_ZERO;
            else if (next_cnt > 0)
                state_d = BAL_POS;
            else
                state_d = BAL_NEG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BAL_BLANK;
            disp_q  <= '0;
        end else begin
            state_q <= state_d;
            disp_q  <= disp_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sym_q <= ctrl_token(2'b00);
        else
            sym_q <= sym_d;
    end

    assign sym = sym_q;

endmodule

// File: rtl/dvi_tmds_lane.sv
module dvi_tmds_lane
    import dvi_tmds_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix,
    input  logic             de,
    input  logic [CTL_W-1:0] ctl,
    output sym_t             sym
);
    logic [PIX_W:0] qm_c;
    stage1_t        s1_q;

    dvi_tmds_minimize u_min (
        .pix (pix),
        .qm  (qm_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s1_q <= '0;
        else
            s1_q <= '{de: de, ctl: ctl, qm: qm_c};
    end

    dvi_tmds_balance u_bal (
        .clk   (clk),
        .rst_n (rst_n),
        .de    (s1_q.de),
        .ctl   (s1_q.ctl),
        .qm    (s1_q.qm),
        .sym   (sym)
    );

endmodule

// File: rtl/dvi_tmds_encoder.sv
module dvi_tmds_encoder
    import dvi_tmds_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] red,
    input  logic [PIX_W-1:0] green,
    input  logic [PIX_W-1:0] blue,
    input  logic             de,
    input  logic             hsync,
    input  logic             vsync,
    input  logic [2:0]       aux,
    output logic [SYM_W-1:0] sym_ch0,
    output logic [SYM_W-1:0] sym_ch1,
    output logic [SYM_W-1:0] sym_ch2
);
    logic [PIX_W-1:0] lane_pix [NUM_CH];
    logic [CTL_W-1:0] lane_ctl [NUM_CH];
    sym_t             lane_sym [NUM_CH];

    assign lane_pix[0] = blue;
    assign lane_pix[1] = green;
    assign lane_pix[2] = red;

    assign lane_ctl[0] = {vsync, hsync};
    assign lane_ctl[1] = {1'b0, aux[0]};
    assign lane_ctl[2] = {aux[2], aux[1]};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        dvi_tmds_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .pix   (lane_pix[g]),
            .de    (de),
            .ctl   (lane_ctl[g]),
            .sym   (lane_sym[g])
        );
    end

    assign sym_ch0 = lane_sym[0];
    assign sym_ch1 = lane_sym[1];
    assign sym_ch2 = lane_sym[2];

endmodule

// File: rtl/dvi_tmds_encoder_chk.sv
module dvi_tmds_encoder_chk
    import dvi_tmds_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [PIX_W-1:0] red,
    input logic [PIX_W-1:0] green,
    input logic [PIX_W-1:0] blue,
    input logic             de,
    input logic             hsync,
    input logic             vsync,
    input logic [2:0]       aux,
    input logic [SYM_W-1:0] sym_ch0,
    input logic [SYM_W-1:0] sym_ch1,
    input logic [SYM_W-1:0] sym_ch2
);
    logic             de_d1, de_d2;
    logic [4:0]       ctl_d1, ctl_d2;
    logic [PIX_W-1:0] blue_d1, blue_d2;
    sym_t             syms [NUM_CH];

    assign syms[0] = sym_ch0;
    assign syms[1] = sym_ch1;
    assign syms[2] = sym_ch2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            de_d1 <= 1'b0; de_d2 <= 1'b0;
            ctl_d1 <= '0;  ctl_d2 <= '0;
            blue_d1 <= '0; blue_d2 <= '0;
        end else begin
            de_d1 <= de;   de_d2 <= de_d1;
            ctl_d1 <= {aux, vsync, hsync}; ctl_d2 <= ctl_d1;
            blue_d1 <= blue; blue_d2 <= blue_d1;
        end
    end

    function automatic logic is_token(input sym_t s);
        return (s == ctrl_token(2'b00)) || (s == ctrl_token(2'b01)) ||
               (s == ctrl_token(2'b10)) || (s == ctrl_token(2'b11));
    endfunction

    function automatic logic xor_chosen(input logic [PIX_W-1:0] b);
        int n;
        n = $countones(b);
        return !((n > PIX_W / 2) || ((n == PIX_W / 2) && !b[0]));
    endfunction

    // R4
    ch0_blank_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de_d2 |-> sym_ch0 == ctrl_token(ctl_d2[1:0]));

    // R5
    aux_blank_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de_d2 |-> (sym_ch1 == ctrl_token({1'b0, ctl_d2[2]})) &&
                   (sym_ch2 == ctrl_token(ctl_d2[4:3])));

    // R11
    video_not_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_d2 |-> !is_token(sym_ch0) && !is_token(sym_ch1) && !is_token(sym_ch2));

    // R6
    chain_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_d2 |-> sym_ch0[PIX_W] == xor_chosen(blue_d2));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bal
        logic signed [7:0] acc;
        int                sbal;

        always_comb sbal = 2 * $countones(syms[g]) - SYM_W;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc <= '0;
            else if (de_d2)
                acc <= acc + 8'(sbal);
            else
                acc <= '0;
        end

        // R9
        disp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc <= 8'sd8) && (acc >= -8'sd8));
    end

endmodule

bind dvi_tmds_encoder dvi_tmds_encoder_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .red     (red),
    .green   (green),
    .blue    (blue),
    .de      (de),
    .hsync   (hsync),
    .vsync   (vsync),
    .aux     (aux),
    .sym_ch0 (sym_ch0),
    .sym_ch1 (sym_ch1),
    .sym_ch2 (sym_ch2)
);

// File: tb/dvi_tmds_encoder_tb_top.sv
module dvi_tmds_encoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] red, green, blue;
    logic       de, hsync, vsync;
    logic [2:0] aux;
    logic [9:0] sym_ch0, sym_ch1, sym_ch2;

    dvi_tmds_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .red(red), .green(green), .blue(blue),
        .de(de), .hsync(hsync), .vsync(vsync), .aux(aux),
        .sym_ch0(sym_ch0), .sym_ch1(sym_ch1), .sym_ch2(sym_ch2)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [9:0] s [3];
        bit         de;
        string      tag;
    } exp_t;

    exp_t  q [$];
    int    disp [3];
    int    seen [3];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_tag = "R2";

    localparam logic [9:0] T00 = 10'b1101010100;
    localparam logic [9:0] T01 = 10'b0010101011;
    localparam logic [9:0] T10 = 10'b0101010100;
    localparam logic [9:0] T11 = 10'b1010101011;

    function automatic logic [9:0] tok(input logic [1:0] c);
        if (c == 2'd0) return T00;
        if (c == 2'd1) return T01;
        if (c == 2'd2) return T10;
        return T11;
    endfunction

    function automatic logic [9:0] ref_sym(int ch, logic [7:0] v, bit en, logic [1:0] c);
        int ones, nq, e;
        bit xn, inv;
        logic [7:0] m;
        logic [9:0] o;
        if (!en) begin
            disp[ch] = 0;
            return tok(c);
        end
        ones = $countones(v);
        xn = (ones > 4) || (ones == 4 && v[0] == 1'b0);
        m[0] = v[0];
        for (int i = 1; i < 8; i++) m[i] = xn ? !(m[i-1] ^ v[i]) : (m[i-1] ^ v[i]);
        nq = $countones(m);
        e  = nq - (8 - nq);
        if (disp[ch] == 0 || e == 0) inv = xn;
        else if ((disp[ch] > 0) == (e > 0)) inv = 1;
        else inv = 0;
        o = {inv, !xn, inv ? ~m : m};
        disp[ch] = disp[ch] + 2 * $countones(o) - 10;
        return o;
    endfunction

    task automatic check_eq(string tag, int ch, logic [9:0] got, logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s ch%0d: got %b expected %b", tag, ch, got, exp);
        end
    endtask

    task automatic check_front();
        exp_t e;
        logic [9:0] act [3];
        act[0] = sym_ch0; act[1] = sym_ch1; act[2] = sym_ch2;
        if (q.size() < 2) return;
        e = q.pop_front();
        for (int ch = 0; ch < 3; ch++) begin
            check_eq(e.tag, ch, act[ch], e.s[ch]);
            if (e.de) begin
                checks++;
                if (act[ch] == T00 || act[ch] == T01 || act[ch] == T10 || act[ch] == T11) begin
                    fails++;
                    $display("FAIL R11 ch%0d: got %b expected a non-control symbol", ch, act[ch]);
                end
                seen[ch] = seen[ch] + 2 * $countones(act[ch]) - 10;
                checks++;
                if (seen[ch] > 8 || seen[ch] < -8) begin
                    fails++;
                    $display("FAIL R9 ch%0d: got balance %0d expected within -8..8", ch, seen[ch]);
                end
            end else begin
                seen[ch] = 0;
            end
        end
    endtask

    task automatic cycle(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                         bit en, bit hs, bit vs, logic [2:0] ax);
        exp_t e;
        @(negedge clk);
        check_front();
        red = r; green = g; blue = b; de = en; hsync = hs; vsync = vs; aux = ax;
        e.de  = en;
        e.tag = cur_tag;
        e.s[0] = ref_sym(0, b, en, {vs, hs});
        e.s[1] = ref_sym(1, g, en, {1'b0, ax[0]});
        e.s[2] = ref_sym(2, r, en, ax[2:1]);
        q.push_back(e);
    endtask

    task automatic video(logic [7:0] r, logic [7:0] g, logic [7:0] b);
        cycle(r, g, b, 1'b1, 1'($urandom), 1'($urandom), 3'($urandom));
    endtask

    task automatic blank(logic [1:0] sy, logic [2:0] ax);
        cycle(8'($urandom), 8'($urandom), 8'($urandom), 1'b0, sy[0], sy[1], ax);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: got no completion expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        exp_t p;
        logic [7:0] edge_vals [8];
        void'($urandom(7));
        rst_n = 1'b0; red = '0; green = '0; blue = '0;
        de = 1'b0; hsync = 1'b0; vsync = 1'b0; aux = '0;
        for (int c = 0; c < 3; c++) begin disp[c] = 0; seen[c] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset value on every lane
        check_eq("R1", 0, sym_ch0, T00);
        check_eq("R1", 1, sym_ch1, T00);
        check_eq("R1", 2, sym_ch2, T00);
        rst_n = 1'b1;
        p.de = 1'b0; p.tag = "R1 R2";
        for (int c = 0; c < 3; c++) p.s[c] = T00;
        q.push_back(p);

        // R3 R4 R5 R10: every control combination, pixels random
        cur_tag = "R3 R4 R5 R10";
        for (int k = 0; k < 32; k++) blank(k[1:0], k[4:2]);

        // R8: first video after reset starts from zero count
        cur_tag = "R8 R7";
        video(8'h00, 8'hFF, 8'h3C);

        // R2 R6 R7 R10: random video with random sync and aux
        cur_tag = "R2 R6 R7 R10";
        for (int k = 0; k < 200; k++) video(8'($urandom), 8'($urandom), 8'($urandom));

        // R6: values at and around the chaining tie
        cur_tag = "R6";
        edge_vals = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h01, 8'hFE};
        for (int k = 0; k < 8; k++) video(edge_vals[k], edge_vals[7-k], edge_vals[(k+3)%8]);

        // R9 R7: long constant runs drive the count to its limits
        cur_tag = "R9 R7";
        for (int k = 0; k < 30; k++) video(8'h10, 8'h00, 8'hFF);
        for (int k = 0; k < 30; k++) video(8'h7F, 8'h81, 8'h03);

        // R8: one blanking cycle then identical video resumes from zero
        cur_tag = "R8";
        blank(2'b11, 3'b101);
        for (int k = 0; k < 4; k++) video(8'h10, 8'h00, 8'hFF);

        // R2 R8: data-enable toggling every cycle
        cur_tag = "R2 R8";
        for (int k = 0; k < 40; k++) begin
            if (k % 2 == 0) video(8'($urandom), 8'($urandom), 8'($urandom));
            else blank(2'($urandom), 3'($urandom));
        end

        cur_tag = "R3 R4 R5";
        blank(2'b00, 3'b000);
        blank(2'b00, 3'b000);
        blank(2'b00, 3'b000);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule